// File: doc/BRIEF.md
# Reset Supervisor with Debounced Button and Strobe Watchdog

This block drives the reset of a processor system from three causes. A supply-good flag, once it goes false, holds reset; when it returns true, reset is kept for a fixed stretch. An active-low pushbutton is synchronized and filtered so that only a press held for a minimum time is accepted. An accepted press holds reset for as long as the button stays down, and reset is then stretched after release. A watchdog that cannot be turned off expects a falling edge on a strobe input within one of three selectable windows. If no falling edge arrives in time, it forces a reset, and that reset is stretched like the others.

All durations are counted in ticks. A prescaler makes one tick every `TICK_CYCLES` clocks, so the defaults give one tick per millisecond at a 100 MHz clock. The stretch, filter and watchdog limits are tick-count parameters, which lets a simulation use short values. The strobe and button pass through two-flop synchronizers. The supply flag and the timeout select arrive as clean synchronous inputs.

Top module: `rsup_supervisor`

## Requirements
- R1: `rst_out` and `rst_out_n` are always opposite. A system reset (`rst` high) drives `rst_out` to 1.
- R2: The prescaler produces exactly one tick every `TICK_CYCLES` clocks. All durations below are measured in these ticks.
- R3: While `pwr_ok` is 0, `rst_out` is 1 from the clock edge that follows the drop.
- R4: After `pwr_ok` is 1 again, or after the system reset ends, reset is released between `STRETCH_TICKS` and `STRETCH_TICKS`+1 ticks later, provided no other cause is present.
- R5: A low pulse on `pb_n` shorter than (`DEB_TICKS`-1) tick periods never asserts reset.
- R6: A low level on `pb_n` that lasts `DEB_TICKS` tick periods plus the synchronizer latency always asserts reset. Reset stays on while the button is held and is released between `STRETCH_TICKS` and `STRETCH_TICKS`+1 ticks after `pb_n` returns high.
- R7: The timeout select decodes as follows: 2'b00 gives `WD_SHORT_TICKS`, 2'b01 gives `WD_MID_TICKS`, and both 2'b10 and 2'b11 give `WD_LONG_TICKS`. With no valid strobe, the watchdog expires between limit-1 and limit ticks after its last restart.
- R8: Only a high-to-low transition of `strobe` restarts the watchdog, and it restarts from zero. A rising edge or a steady level has no effect.
- R9: The watchdog count is held at zero while reset is asserted and starts from zero when reset is released. Strobe activity during reset has no effect.
- R10: Watchdog expiry asserts reset, which is then stretched as in R4. The watchdog cannot be disabled, so with no strobe it expires again after every release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| pwr_ok | input | 1 | Supply-good flag, 1 = supply in tolerance |
| pb_n | input | 1 | Pushbutton, active low, asynchronous |
| strobe | input | 1 | Watchdog strobe; falling edges restart the timer |
| wd_sel | input | 2 | Watchdog timeout select (see R7) |
| rst_out | output | 1 | Reset, active high |
| rst_out_n | output | 1 | Reset, active low |

## Verification
The hardest case to reach from the ports is telling a rising strobe edge apart from a falling one, because both must occur while the watchdog is running and between the restart points. The bench uses the reset release as a known restart point and holds the strobe at a steady level. It then applies a single edge a fixed number of cycles later and measures when the following reset arrives. A falling edge moves the expiry by that offset, and a rising edge must leave the expiry where it would have been with no edge at all. Strobe activity during reset is tested the same way: the bench toggles the strobe throughout a supply-low period and the stretch that follows, then checks that the next expiry is still timed from the release.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

    typedef enum logic [1:0] {
        WD_SEL_SHORT = 2'b00,
        WD_SEL_MID   = 2'b01,
        WD_SEL_LONG  = 2'b10,
        WD_SEL_LONG2 = 2'b11
    } wd_sel_e;

    typedef struct packed {
        logic pb_n;
        logic strobe;
    } sup_raw_t;

    function automatic int unsigned cnt_width(input int unsigned maxv);
        return (maxv < 2) ? 1 : $clog2(maxv + 1);
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int unsigned wd_limit(input wd_sel_e sel, input int unsigned t_s,
                                             input int unsigned t_m, input int unsigned t_l);
        case (sel)
            WD_SEL_SHORT: return t_s;
            WD_SEL_MID:   return t_m;
            default:      return t_l;
        endcase
    endfunction

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
    parameter int unsigned          WIDTH   = 1,
    parameter int unsigned          STAGES  = 2,
    parameter logic [WIDTH-1:0]     RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= {STAGES{RST_VAL}};
        else     stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/rsup_tick.sv
module rsup_tick
    import rsup_pkg::*;
#(
    parameter int unsigned TICK_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned    CW   = cnt_width(TICK_CYCLES - 1);
    localparam logic [CW-1:0]  LAST = CW'(TICK_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> ((TICK_CYCLES == 1) || !tick));
endmodule

// File: rtl/rsup_pb_filter.sv
module rsup_pb_filter
    import rsup_pkg::*;
#(
    parameter int unsigned DEB_TICKS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic pb_n_s,
    output logic held
);
    localparam int unsigned   CW  = cnt_width(DEB_TICKS);
    localparam logic [CW-1:0] ACC = CW'(DEB_TICKS);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || pb_n_s)                 low_cnt <= '0;
        else if (tick && (low_cnt != ACC)) low_cnt <= low_cnt + 1'b1;
    end

    assign held = !pb_n_s && (low_cnt == ACC);

    // R5
    accept_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(held) |-> ($past(tick) && !$past(pb_n_s)));
endmodule

// File: rtl/rsup_wdog.sv
module rsup_wdog
    import rsup_pkg::*;
#(
    parameter int unsigned T_SHORT = 150,
    parameter int unsigned T_MID   = 610,
    parameter int unsigned T_LONG  = 1200
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    rst_active,
    input  logic    strobe_s,
    input  wd_sel_e sel,
    output logic    expire
);
    localparam int unsigned   LMAX = max3(T_SHORT, T_MID, T_LONG);
    localparam int unsigned   CW   = cnt_width(LMAX);
    localparam logic [CW-1:0] CMAX = CW'(LMAX);

    logic          strobe_d;
    logic          fall;
    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    always_ff @(posedge clk) begin
        if (rst) strobe_d <= 1'b0;
        else     strobe_d <= strobe_s;
    end

    assign fall   = strobe_d && !strobe_s;
    assign limit  = CW'(wd_limit(sel, T_SHORT, T_MID, T_LONG));
    assign expire = !rst_active && (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || rst_active || fall || expire) cnt <= '0;
        else if (tick)                           cnt <= cnt + 1'b1;
    end

    // R9
    held_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
        rst_active |=> (cnt == '0));

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CMAX);

    // R8
    only_fall_restarts_chk: assert property (@(posedge clk) disable iff (rst)
        (!fall && !rst_active && !expire) |=> (cnt >= $past(cnt)));
endmodule

// File: rtl/rsup_supervisor.sv
module rsup_supervisor
    import rsup_pkg::*;
#(
    parameter int unsigned TICK_CYCLES    = 100000,
    parameter int unsigned STRETCH_TICKS  = 250,
    parameter int unsigned DEB_TICKS      = 20,
    parameter int unsigned WD_SHORT_TICKS = 150,
    parameter int unsigned WD_MID_TICKS   = 610,
    parameter int unsigned WD_LONG_TICKS  = 1200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_ok,
    input  logic       pb_n,
    input  logic       strobe,
    input  logic [1:0] wd_sel,
    output logic       rst_out,
    output logic       rst_out_n
);
    localparam int unsigned   SW  = cnt_width(STRETCH_TICKS);
    localparam logic [SW-1:0] STR = SW'(STRETCH_TICKS);

    sup_raw_t      raw_in;
    sup_raw_t      raw_s;
    logic          tick;
    logic          pb_held;
    logic          wd_expire;
    logic          cause;
    logic          rst_q;
    logic [SW-1:0] st_cnt;

    assign raw_in = '{pb_n: pb_n, strobe: strobe};

    rsup_sync #(
        .WIDTH   ($bits(sup_raw_t)),
        .STAGES  (2),
        .RST_VAL (sup_raw_t'{pb_n: 1'b1, strobe: 1'b0})
    ) in_sync_i (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (raw_s)
    );

    rsup_tick #(.TICK_CYCLES(TICK_CYCLES)) tick_i (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    rsup_pb_filter #(.DEB_TICKS(DEB_TICKS)) pb_i (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .pb_n_s (raw_s.pb_n),
        .held   (pb_held)
    );

    rsup_wdog #(
        .T_SHORT (WD_SHORT_TICKS),
        .T_MID   (WD_MID_TICKS),
        .T_LONG  (WD_LONG_TICKS)
    ) wdog_i (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .rst_active (rst_q),
        .strobe_s   (raw_s.strobe),
        .sel        (wd_sel_e'(wd_sel)),
        .expire     (wd_expire)
    );

    assign cause = !pwr_ok || pb_held || wd_expire;

    always_ff @(posedge clk) begin
        if (rst || cause) begin
            rst_q  <= 1'b1;
            st_cnt <= '0;
        end else if (rst_q && tick) begin
            if (st_cnt == STR) rst_q  <= 1'b0;
            else               st_cnt <= st_cnt + 1'b1;
        end
    end

    assign rst_out   = rst_q;
    assign rst_out_n = !rst_q;

    // R3
    supply_low_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |=> rst_q);

    // R6
    button_held_chk: assert property (@(posedge clk) disable iff (rst)
        pb_held |=> rst_q);

    // R10
    wdog_expiry_chk: assert property (@(posedge clk) disable iff (rst)
        wd_expire |=> rst_q);

    // R4
    release_after_stretch_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_q) |-> ($past(pwr_ok) && ($past(st_cnt) == STR)));
endmodule

// File: tb/rsup_supervisor_tb.sv
module rsup_supervisor_tb_top;
    localparam int T   = 4;
    localparam int STR = 10;
    localparam int DEB = 5;
    localparam int WS  = 6;
    localparam int WM  = 12;
    localparam int WL  = 20;
    localparam int REL_LO = STR * T;
    localparam int REL_HI = (STR + 1) * T + 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_ok = 1'b1;
    logic       pb_n = 1'b1;
    logic       strobe = 1'b0;
    logic [1:0] wd_sel = 2'b10;
    logic       rst_out;
    logic       rst_out_n;

    int  checks = 0;
    int  fails = 0;
    int  comp_bad = 0;
    bit  feed = 1'b0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    rsup_supervisor #(
        .TICK_CYCLES    (T),
        .STRETCH_TICKS  (STR),
        .DEB_TICKS      (DEB),
        .WD_SHORT_TICKS (WS),
        .WD_MID_TICKS   (WM),
        .WD_LONG_TICKS  (WL)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .pwr_ok    (pwr_ok),
        .pb_n      (pb_n),
        .strobe    (strobe),
        .wd_sel    (wd_sel),
        .rst_out   (rst_out),
        .rst_out_n (rst_out_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_rng(input string tag, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_for(input logic lvl, input int lim, output int n);
        n = 0;
        while (rst_out !== lvl && n < lim) begin
            @(negedge clk);
            n++;
        end
    endtask

    function automatic int wd_lim(input int sel);
        case (sel)
            0:       return WS;
            1:       return WM;
            default: return WL;
        endcase
    endfunction

    // strobe feeder: a falling edge every 16 clocks while enabled
    initial begin
        int fc;
        fc = 0;
        forever begin
            @(negedge clk);
            if (feed) begin
                fc++;
                if (fc == 8) begin
                    strobe = ~strobe;
                    fc = 0;
                end
            end else begin
                fc = 0;
            end
        end
    end

    // R1 complement monitor
    always @(negedge clk) begin
        if (!rst && rst_out === rst_out_n) comp_bad++;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired before the sequence completed");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        int n2;
        bit seen;

        step(3);
        // R1: reset state
        check(rst_out === 1'b1 && rst_out_n === 1'b0, "R1 reset state", int'(rst_out), 1);
        rst = 1'b0;
        wait_for(1'b0, 200, n);
        // R4 and R2: power-on stretch after system reset
        check_rng("R4 power-on release", n, REL_LO, REL_HI);

        feed = 1'b1;
        // R3: supply drop
        pwr_ok = 1'b0;
        step(1);
        check(rst_out === 1'b1, "R3 assert on drop", int'(rst_out), 1);
        step(30);
        check(rst_out === 1'b1, "R3 held while low", int'(rst_out), 1);
        pwr_ok = 1'b1;
        wait_for(1'b0, 200, n);
        check_rng("R4 release after supply returns", n, REL_LO, REL_HI);

        // R5: short button pulses are rejected
        for (int len = 1; len <= (DEB - 1) * T - 1; len++) begin
            seen = 1'b0;
            pb_n = 1'b0;
            repeat (len) begin
                @(negedge clk);
                if (rst_out) seen = 1'b1;
            end
            pb_n = 1'b1;
            repeat (6) begin
                @(negedge clk);
                if (rst_out) seen = 1'b1;
            end
            check(!seen, $sformatf("R5 short press len=%0d", len), int'(seen), 0);
        end

        // R6: accepted presses
        for (int h = 0; h < 3; h++) begin
            pb_n = 1'b0;
            wait_for(1'b1, 60, n);
            check_rng("R6 press accepted", n, (DEB - 1) * T + 1, DEB * T + 3);
            step(h * 20);
            check(rst_out === 1'b1, "R6 held while pressed", int'(rst_out), 1);
            pb_n = 1'b1;
            wait_for(1'b0, 200, n2);
            check_rng("R6 release after button up", n2, REL_LO, REL_HI);
        end

        // R7, R10: timeout select sweep with no strobe, two expiries each
        feed = 1'b0;
        step(1);
        strobe = 1'b0;
        pwr_ok = 1'b0;
        step(2);
        pwr_ok = 1'b1;
        wait_for(1'b0, 200, n);
        for (int s = 0; s < 4; s++) begin
            wd_sel = 2'(s);
            for (int k = 0; k < 2; k++) begin
                if (k == 1 || s > 0) begin
                    wait_for(1'b0, 200, n2);
                    check_rng($sformatf("R10 stretch after expiry sel=%0d", s), n2, REL_LO - 1, REL_HI);
                end
                wait_for(1'b1, 400, n);
                check_rng($sformatf("R7 timeout sel=%0d", s), n,
                          (wd_lim(s) - 1) * T + 1, wd_lim(s) * T + 2);
            end
        end

        // R8: a rising edge does not restart
        wd_sel = 2'b00;
        wait_for(1'b0, 200, n);
        step(8);
        strobe = 1'b1;
        wait_for(1'b1, 400, n);
        check_rng("R8 rising edge ignored", n + 8, (WS - 1) * T + 1, WS * T + 2);

        // R8: a falling edge restarts from zero
        wait_for(1'b0, 200, n);
        step(12);
        strobe = 1'b0;
        wait_for(1'b1, 400, n);
        check_rng("R8 falling edge restarts", n + 12, (WS - 1) * T + 4 + 12, WS * T + 5 + 12);

        // R9: strobe activity during reset is ignored
        wait_for(1'b0, 200, n);
        pwr_ok = 1'b0;
        for (int i = 0; i < 10; i++) begin
            strobe = ~strobe;
            step(2);
        end
        pwr_ok = 1'b1;
        for (int i = 0; i < 10; i++) begin
            strobe = ~strobe;
            step(2);
        end
        strobe = 1'b0;
        wait_for(1'b0, 200, n);
        check_rng("R9 release unaffected by strobe", n + 20, REL_LO, REL_HI);
        wait_for(1'b1, 400, n);
        check_rng("R9 count starts at release", n, (WS - 1) * T + 1, WS * T + 2);

        // R8: regular falling edges keep reset off
        wait_for(1'b0, 200, n);
        feed = 1'b1;
        seen = 1'b0;
        repeat (400) begin
            @(negedge clk);
            if (rst_out) seen = 1'b1;
        end
        check(!seen, "R8 fed watchdog never fires", int'(seen), 0);
        feed = 1'b0;

        // R1: outputs complementary throughout
        check(comp_bad == 0, "R1 outputs complementary", comp_bad, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule